// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This block is the digital controller of a battery-charging safety switch. It reads synchronous flags from analog comparators and sensing circuits: a power-good release, an active-low enable, input overvoltage, overcurrent, battery overvoltage, and a die-temperature trip with a separate cool-down release. From these it decides when the pass switch may conduct, when the soft-start ramp runs, and when the active-low fault line is pulled down.

Startup runs in a fixed order. After power is good and the block is enabled, the switch waits through a settle interval. It then ramps and finally stays on. Each fault class has its own response. Input overvoltage cuts the switch off in the same cycle, with no filtering. Overcurrent and battery overvoltage must persist through a blanking window before they count, and either class reaching sixteen qualified events locks the switch off. A thermal trip holds the switch off until the cool-down flag arrives. After any fault that does not lock, the block restarts from the settle interval once the cause is gone.

All times are parameters counted in clock cycles. The settle, blanking and ramp lengths are set from the chip's clock rate.

Top module: `chg_guard_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), with por_i low and en_n_i low and no fault, sw_on_o stays low for SETTLE_CYC clock edges. Then ramp_req_o and sw_on_o are both high for RAMP_CYC edges. After that, sw_on_o stays high and ramp_req_o stays low.
- R2: While in_ovp_i is high, sw_on_o and ramp_req_o are low in that same cycle and fault_n_o is low. Once in_ovp_i falls, the full settle interval and the ramp run again before the switch is on steadily.
- R3: If in_ovp_i stays high through the settle interval, sw_on_o never rises until in_ovp_i has been low for SETTLE_CYC edges.
- R4: A high run of ocp_i or bat_ovp_i that lasts fewer than BLANK_CYC consecutive edges has no effect on any output. A run of BLANK_CYC edges pulls fault_n_o low after the BLANK_CYC-th edge and turns sw_on_o off after the next edge.
- R5: Overcurrent and battery overvoltage each have their own 4-bit count of qualified events. The sixteenth qualified event in either class sets a lock that holds sw_on_o low.
- R6: The lock and both counts clear only when rst_n is low at an edge, when por_i is high, or when en_n_i is high. After such a clear, startup proceeds as in R1.
- R7: A high ot_trip_i holds the switch off. The switch stays off until ot_clear_i is seen high; when both are high at once, the trip wins.
- R8: fault_n_o is low exactly while any of these holds: in_ovp_i is high, a blanked fault is qualified, the thermal hold is set, or the lock is set.
- R9: While en_n_i or por_i is high, sw_on_o and ramp_req_o are low in that same cycle, and startup restarts from the settle interval.
- R10: After a blanked fault turns the switch off and no lock is set, the block retries through the settle interval and the ramp once the flag has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_i | input | 1 | High while supply is below power-good |
| en_n_i | input | 1 | Active-low enable |
| in_ovp_i | input | 1 | Input overvoltage flag |
| ocp_i | input | 1 | Overcurrent flag (blanked) |
| bat_ovp_i | input | 1 | Battery overvoltage flag (blanked) |
| ot_trip_i | input | 1 | Die temperature above upper threshold |
| ot_clear_i | input | 1 | Die temperature below lower threshold |
| sw_on_o | output | 1 | Pass switch enable |
| ramp_req_o | output | 1 | Soft-start ramp request |
| fault_n_o | output | 1 | Active-low fault indication |

## Verification
The bench builds the block with SETTLE_CYC=20, BLANK_CYC=6 and RAMP_CYC=8 instead of the millisecond-scale defaults. With these values a full startup takes under thirty cycles. That makes it practical to drive sixteen qualified battery-overvoltage pulses into the lock, run the retry after each kind of fault, and test pulses exactly one cycle shorter than the blanking window, all in a short run. The counter width stays at its default of 4 bits, so the sixteen-event lock is tested at its real depth.

// File: rtl/chg_guard_pkg.sv
// Package: shared types for the charger protection sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package chg_guard_pkg;

    // Startup phase of the pass switch.
    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_RAMP   = 2'd1,
        ST_ON     = 2'd2
    } start_st_e;

    // Index of each blanked fault class inside the slow-fault vectors.
    localparam int SLOW_OCP  = 0;
    localparam int SLOW_BOVP = 1;
    localparam int N_SLOW    = 2;

endpackage

// File: rtl/chg_blank_filter.sv
// Module: chg_blank_filter
// Qualifies a comparator flag only after it has been high for BLANK_CYC
// consecutive clock edges. qual_o stays high while the flag stays high.
// evt_o pulses for one cycle on the edge at which qualification happens.
// Assumes: flag_i is synchronous to clk, and BLANK_CYC >= 1.
module chg_blank_filter #(
    parameter int BLANK_CYC = 22500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic qual_o,
    output logic evt_o
);
    localparam int CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(BLANK_CYC);
    localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

    logic [CW-1:0] run_q;

    // Count consecutive high samples; the count saturates at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= '0;
        else if (!flag_i)        run_q <= '0;
        else if (run_q != FULL)  run_q <= run_q + 1'b1;
    end

    // Qualification level and the one-cycle event pulse.
    always_comb begin
        qual_o = (run_q == FULL);
        evt_o  = flag_i && (run_q == LAST);
    end

    AST_SHORT_PULSE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_i |=> !qual_o); // R4
endmodule

// File: rtl/chg_evt_counter.sv
// Module: chg_evt_counter
// Counts qualified events of one fault class. On the 2**CNT_W-th event it
// sets a sticky lock. clr_i clears both the count and the lock.
// Assumes: evt_i is a single-cycle pulse, and clr_i takes priority over evt_i.
module chg_evt_counter #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic evt_i,
    output logic lock_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             lock_q;

    // Accumulate events; the event after the top count sets the lock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (evt_i) begin
            if (cnt_q == TOP) lock_q <= 1'b1;
            else              cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Drive the lock output.
    always_comb lock_o = lock_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_q == TOP) |=> (cnt_q == TOP)); // R5
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && lock_q) |=> lock_q); // R6
endmodule

// File: rtl/chg_thermal_hold.sv
// Module: chg_thermal_hold
// Hysteresis latch for die temperature. The upper-threshold trip sets it and
// the lower-threshold release clears it. If both are high, the trip wins.
// Assumes: both flags come from synchronised comparators.
module chg_thermal_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic ot_trip_i,
    input  logic ot_clear_i,
    output logic hot_o
);
    logic hot_q;

    // Set on trip; release only on the cool-down flag.
    always_ff @(posedge clk) begin
        if (!rst_n)          hot_q <= 1'b0;
        else if (ot_trip_i)  hot_q <= 1'b1;
        else if (ot_clear_i) hot_q <= 1'b0;
    end

    // Drive the hold output.
    always_comb hot_o = hot_q;

    AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_q && !ot_clear_i) |=> hot_q); // R7
    AST_COLD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_q && !ot_trip_i) |=> !hot_q); // R7
endmodule

// File: rtl/chg_start_fsm.sv
// Module: chg_start_fsm
// Runs the startup order: settle interval, then soft-start ramp, then steady
// on. A registered block request sends it back to the start of the settle
// interval. The fast cut input gates the outputs in the same cycle.
// Assumes: SETTLE_CYC >= 1 and RAMP_CYC >= 1.
module chg_start_fsm
    import chg_guard_pkg::*;
#(
    parameter int SETTLE_CYC = 1250000,
    parameter int RAMP_CYC   = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_i,
    input  logic cut_i,
    output logic sw_on_o,
    output logic ramp_o
);
    localparam int MAXC = (SETTLE_CYC > RAMP_CYC) ? SETTLE_CYC : RAMP_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] SET_LAST  = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] RAMP_LAST = TW'(RAMP_CYC - 1);

    start_st_e     st_q;
    logic [TW-1:0] tmr_q;

    // Phase sequencing with a shared phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_i) begin
            st_q  <= ST_SETTLE;
            tmr_q <= '0;
        end else begin
            unique case (st_q)
                ST_SETTLE: begin
                    if (tmr_q == SET_LAST) begin
                        st_q  <= ST_RAMP;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_RAMP: begin
                    if (tmr_q == RAMP_LAST) begin
                        st_q  <= ST_ON;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= ST_ON;
                    tmr_q <= '0;
                end
            endcase
        end
    end

    // Output gating: the fast cut acts without waiting for a clock edge.
    always_comb begin
        sw_on_o = (st_q != ST_SETTLE) && !cut_i;
        ramp_o  = (st_q == ST_RAMP) && !cut_i;
    end

    AST_BLOCK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        blk_i |=> (st_q == ST_SETTLE && tmr_q == '0)); // R2
    AST_SETTLE_BEFORE_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RAMP && $past(st_q) != ST_RAMP)
            |-> $past(st_q == ST_SETTLE && tmr_q == SET_LAST)); // R1
endmodule

// File: rtl/chg_guard_seq.sv
// Module: chg_guard_seq (top)
// Charger protection fault sequencer. Combines the fast input-overvoltage cut,
// two blanked fault classes with event counters and a lock, the thermal
// hysteresis hold, and the startup sequencer.
// Assumes: all inputs are already synchronised to clk.
module chg_guard_seq
    import chg_guard_pkg::*;
#(
    parameter int SETTLE_CYC = 1250000,
    parameter int BLANK_CYC  = 22500,
    parameter int RAMP_CYC   = 125000,
    parameter int CNT_W      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_i,
    input  logic en_n_i,
    input  logic in_ovp_i,
    input  logic ocp_i,
    input  logic bat_ovp_i,
    input  logic ot_trip_i,
    input  logic ot_clear_i,
    output logic sw_on_o,
    output logic ramp_req_o,
    output logic fault_n_o
);
    logic [N_SLOW-1:0] slow_flag;
    logic [N_SLOW-1:0] slow_qual;
    logic [N_SLOW-1:0] slow_evt;
    logic [N_SLOW-1:0] slow_lock;
    logic              cnt_clr;
    logic              hot;
    logic              locked;
    logic              cut;
    logic              blk;

    // Gather the blanked fault flags by class index.
    always_comb begin
        slow_flag            = '0;
        slow_flag[SLOW_OCP]  = ocp_i;
        slow_flag[SLOW_BOVP] = bat_ovp_i;
    end

    // Lock and counter clear request: supply not good, or block disabled.
    always_comb cnt_clr = por_i || en_n_i;

    for (genvar g = 0; g < N_SLOW; g++) begin : g_slow
        chg_blank_filter #(.BLANK_CYC(BLANK_CYC)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .flag_i (slow_flag[g]),
            .qual_o (slow_qual[g]),
            .evt_o  (slow_evt[g])
        );
        chg_evt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (cnt_clr),
            .evt_i  (slow_evt[g]),
            .lock_o (slow_lock[g])
        );
    end

    chg_thermal_hold u_therm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ot_trip_i  (ot_trip_i),
        .ot_clear_i (ot_clear_i),
        .hot_o      (hot)
    );

    // Fault merge: fast cut, full block request, and fault line.
    always_comb begin
        locked    = |slow_lock;
        cut       = in_ovp_i || en_n_i || por_i;
        blk       = cut || (|slow_qual) || hot || locked;
        fault_n_o = !(in_ovp_i || (|slow_qual) || hot || locked);
    end

    chg_start_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .RAMP_CYC   (RAMP_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .blk_i   (blk),
        .cut_i   (cut),
        .sw_on_o (sw_on_o),
        .ramp_o  (ramp_req_o)
    );

    AST_LOCK_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !cnt_clr) |=> !sw_on_o); // R5
    AST_OVP_FAULT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ovp_i && sw_on_o) |-> 1'b0); // R2
endmodule

// File: tb/chg_guard_seq_tb.sv
// Bench: behavioural per-cycle reference model compared with the outputs on every clock.
module chg_guard_seq_tb;
    localparam int SETTLE = 20;
    localparam int BLANK  = 6;
    localparam int RAMP   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por = 1'b0, en_n = 1'b0, ovp = 1'b0, ocp = 1'b0, bovp = 1'b0;
    logic ot_trip = 1'b0, ot_clr = 1'b0;
    logic sw_on, ramp_req, fault_n;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    chg_guard_seq #(.SETTLE_CYC(SETTLE), .BLANK_CYC(BLANK), .RAMP_CYC(RAMP)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_i(por), .en_n_i(en_n), .in_ovp_i(ovp),
        .ocp_i(ocp), .bat_ovp_i(bovp), .ot_trip_i(ot_trip), .ot_clear_i(ot_clr),
        .sw_on_o(sw_on), .ramp_req_o(ramp_req), .fault_n_o(fault_n)
    );

    // Reference model state: phase 0 settle, 1 ramp, 2 on.
    int m_phase = 0, m_tmr = 0;
    int m_run[2] = '{0, 0};
    int m_cnt[2] = '{0, 0};
    bit m_lock[2] = '{0, 0};
    bit m_hot = 0;

    function automatic bit m_qual(int k);
        return m_run[k] == BLANK;
    endfunction

    always @(posedge clk) begin
        bit fl[2];
        bit ev[2];
        bit clr, block;
        fl[0] = ocp; fl[1] = bovp;
        clr = por || en_n;
        block = ovp || clr || m_qual(0) || m_qual(1) || m_hot || m_lock[0] || m_lock[1];
        for (int k = 0; k < 2; k++) ev[k] = fl[k] && (m_run[k] == BLANK - 1);
        if (!rst_n) begin
            m_phase = 0; m_tmr = 0; m_hot = 0;
            for (int k = 0; k < 2; k++) begin m_run[k] = 0; m_cnt[k] = 0; m_lock[k] = 0; end
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (!fl[k]) m_run[k] = 0;
                else if (m_run[k] < BLANK) m_run[k]++;
                if (clr) begin m_cnt[k] = 0; m_lock[k] = 0; end
                else if (ev[k]) begin
                    if (m_cnt[k] == 15) m_lock[k] = 1; else m_cnt[k]++;
                end
            end
            if (ot_trip) m_hot = 1; else if (ot_clr) m_hot = 0;
            if (block) begin m_phase = 0; m_tmr = 0; end
            else if (m_phase == 0) begin
                if (m_tmr == SETTLE - 1) begin m_phase = 1; m_tmr = 0; end else m_tmr++;
            end else if (m_phase == 1) begin
                if (m_tmr == RAMP - 1) begin m_phase = 2; m_tmr = 0; end else m_tmr++;
            end
        end
    end

    task automatic check1(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output once per cycle, away from the active edge.
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            bit cut;
            @(negedge clk);
            #2;
            cut = ovp || en_n || por;
            check1(cur_req, "sw_on", sw_on, (m_phase != 0) && !cut);
            check1(cur_req, "ramp_req", ramp_req, (m_phase == 1) && !cut);
            check1("R8", "fault_n", fault_n,
                   !(ovp || m_qual(0) || m_qual(1) || m_hot || m_lock[0] || m_lock[1]));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1"; step(3);                 // reset state
        rst_n = 1'b1; step(40);                  // R1 full startup
        cur_req = "R2"; ovp = 1'b1; step(1); ovp = 1'b0; step(40);
        cur_req = "R3"; ovp = 1'b1; step(30); ovp = 1'b0; step(40);
        cur_req = "R4"; ocp = 1'b1; step(BLANK - 1); ocp = 1'b0; step(10);
        bovp = 1'b1; step(BLANK - 1); bovp = 1'b0; step(10);
        ocp = 1'b1; step(BLANK + 4);
        cur_req = "R10"; ocp = 1'b0; step(40);
        cur_req = "R7"; ot_trip = 1'b1; step(1); ot_trip = 1'b0; step(30);
        ot_trip = 1'b1; ot_clr = 1'b1; step(1); ot_trip = 1'b0; step(5);
        ot_clr = 1'b0; step(5); ot_clr = 1'b1; step(1); ot_clr = 1'b0; step(40);
        cur_req = "R5";
        for (int p = 0; p < 16; p++) begin
            bovp = 1'b1; step(BLANK + 2); bovp = 1'b0; step(4);
        end
        step(40);
        cur_req = "R9"; en_n = 1'b1; step(3);
        cur_req = "R6"; en_n = 1'b0; step(40);
        for (int p = 0; p < 16; p++) begin
            ocp = 1'b1; step(BLANK + 1); ocp = 1'b0; step(3);
        end
        step(20);
        cur_req = "R9"; por = 1'b1; step(3);
        cur_req = "R6"; por = 1'b0; step(40);
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(35);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule